// File: doc/BRIEF.md
# Byte-Port Packet Mailbox

This block sits between a host CPU and a simple network-side byte interface and moves exactly one frame at a time in each direction. The host reaches it through a 32-bit register port. Every data byte crosses that port in its own register access. The two count registers also act as handshakes. The receive count falls to zero as the host drains bytes. The transmit count is cleared by the device once it has taken a frame.

On the network side, frames arrive on a valid/ready byte stream that carries start and end markers. A beat is transferred on any rising edge where `rx_valid` and `rx_ready` are both high. `rx_ready` stays low from the moment a frame is handed to the host until two things are true: the host has read every byte, and it has acknowledged the receive-done flag. Transmitted frames leave on a second valid/ready byte stream. Once `tx_valid` is raised, it stays high with `tx_data` and `tx_last` unchanged until `tx_ready` accepts the beat.

Interrupt wiring lives elsewhere. This block reports one-cycle done pulses and a test flag. It also keeps W1C pending bits that gate reception.

Register map (byte offsets, word access): 0x00/0x04 identification, 0x08 busy, 0x0C receive count, 0x10 transmit count, 0x14 event control, 0x18 interrupt routing info, 0x1C receive data port, 0x20 transmit data port. Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `mbx_pktdev`

## Requirements
- R1: Reading 0x00 returns 0x45545942 and reading 0x04 returns 0x31545250, the ASCII tag "BYTEPRT" followed by the version digit (VERSION=1), least significant byte first.
- R2: After reset, busy, both counts and the event control register read 0, `rx_ready` is 1 and `tx_valid` is 0.
- R3: When the end beat of a frame with at least one byte is accepted, the receive count reads the number of stored bytes, `evt_rx_done` is high for exactly the next cycle, and bit 1 of event control reads 1.
- R4: Each read of 0x1C returns the next stored byte in bits 7:0 with bits 31:8 zero, and decrements the receive count. A read while the count is zero returns 0 and changes nothing.
- R5: `rx_ready` is 0 while the receive count is nonzero or event control bit 1 is set. Writing 1 to bit 1 clears that bit.
- R6: An end beat with `rx_ben`=0 and no stored bytes ends a zero-length frame, which is discarded: no `evt_rx_done`, the count stays 0, and bit 1 stays 0.
- R7: A beat with `rx_sof`=1 restarts the frame in progress, so bytes stored before it are dropped.
- R8: Bytes beyond DEPTH in one frame are accepted and dropped, and the receive count never exceeds DEPTH (64).
- R9: A nonzero write to 0x10 sets the transmit count, clipped to DEPTH. That many writes to 0x20 store bits 7:0. After the last one, the bytes leave on the transmit stream in order, with `tx_last` only on the final byte. Writes to 0x20 beyond the count are dropped.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold.
- R11: Writes to 0x10 are ignored while the transmit count is nonzero. In the cycle after the final byte is accepted, the count reads 0, `evt_tx_done` is high for one cycle, and event control bit 0 reads 1 until 1 is written to it.
- R12: Busy (0x08 bit 0) reads 1 while a received frame is partly collected or the transmit count is nonzero.
- R13: Writing 0x14 with bit 31 set raises event control bit 31 and `evt_test`. A read of 0x14, or a write of 0x14 with bit 31 clear, drops it again.
- R14: 0x18 reads the INFO parameter (default 2), and 0x20 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Host byte address (word aligned) |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after `bus_rd` |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat accepted |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Beat starts a new frame |
| rx_last | input | 1 | Beat ends the frame |
| rx_ben | input | 1 | Beat carries a byte |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| evt_tx_done | output | 1 | One-cycle transmit completion pulse |
| evt_rx_done | output | 1 | One-cycle receive completion pulse |
| evt_test | output | 1 | Test event flag |

## Verification
The assertions rely on reset being applied before any traffic. They also assume that the host never reads and writes in the same cycle and that the stream inputs are always at known levels. The stimulus changes every input only on the falling clock edge and issues one bus access at a time. It uses only mapped offsets and waits for `rx_ready` before it considers a beat delivered. Frames stay within DEPTH bytes, except for the one scenario that overruns the buffer on purpose. On the transmit side, `tx_ready` is toggled every cycle so that back-pressure hits beats mid-frame.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_FILL = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // word index = byte offset / 4
  localparam logic [3:0] W_ID_LO  = 4'd0;
  localparam logic [3:0] W_ID_HI  = 4'd1;
  localparam logic [3:0] W_BUSY   = 4'd2;
  localparam logic [3:0] W_RXCNT  = 4'd3;
  localparam logic [3:0] W_TXCNT  = 4'd4;
  localparam logic [3:0] W_EVCTL  = 4'd5;
  localparam logic [3:0] W_INFO   = 4'd6;
  localparam logic [3:0] W_RXDATA = 4'd7;
  localparam logic [3:0] W_TXDATA = 4'd8;

  // event control bit positions, decoded by host software
  localparam int EV_TX   = 0;
  localparam int EV_RX   = 1;
  localparam int EV_TEST = 31;

  function automatic logic [63:0] ident_word(input int ver);
    logic [7:0] digit;
    digit = 8'(8'h30 + ver);
    return {digit, 8'h54, 8'h52, 8'h50, 8'h45, 8'h54, 8'h59, 8'h42};
  endfunction

endpackage

// File: rtl/mbx_bytebuf.sv
module mbx_bytebuf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mbx_rx_path.sv
module mbx_rx_path #(
  parameter int DEPTH = 64,
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_sof,
  input  logic          s_last,
  input  logic          s_ben,
  input  logic          pop,
  input  logic          pend_clr,
  output logic [7:0]    pop_data,
  output logic [CW-1:0] count,
  output logic          pend,
  output logic          done_pulse,
  output logic          in_frame
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0] wptr, base, total;
  logic [AW-1:0] rptr;
  logic [7:0]    buf_q;
  logic          hs, store;

  assign s_ready = !pend && (count == '0);
  assign hs      = s_valid && s_ready;
  assign base    = s_sof ? '0 : wptr;
  assign store   = hs && s_ben && (base < PW'(DEPTH));
  assign total   = base + PW'(store);

  mbx_bytebuf #(.DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (store),
    .waddr (base[AW-1:0]),
    .wdata (s_data),
    .raddr (rptr),
    .rdata (buf_q)
  );

  assign pop_data = (count != '0) ? buf_q : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      count      <= '0;
      pend       <= 1'b0;
      done_pulse <= 1'b0;
      in_frame   <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (pend_clr) pend <= 1'b0;
      if (pop && count != '0) begin
        rptr  <= rptr + 1'b1;
        count <= count - 1'b1;
      end
      if (hs) begin
        if (s_last) begin
          wptr     <= '0;
          in_frame <= 1'b0;
          if (total != '0) begin
            count      <= CW'(total);
            rptr       <= '0;
            pend       <= 1'b1;
            done_pulse <= 1'b1;
          end
        end else begin
          wptr     <= total;
          in_frame <= 1'b1;
        end
      end
    end
  end

  p_rx_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_rx_count_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |=> (count <= $past(count)));

  p_rx_hold_while_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !pend_clr) |=> (pend && !(s_valid && s_ready)));
endmodule

// File: rtl/mbx_tx_path.sv
module mbx_tx_path
  import mbx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wval,
  input  logic          dat_we,
  input  logic [7:0]    dat_byte,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic          m_last,
  output logic [CW-1:0] count,
  output logic          done_pulse,
  output logic          active
);
  localparam int AW = $clog2(DEPTH);

  tx_state_e     state;
  logic [CW-1:0] wcnt, rptr, clipped;
  logic          wr_en;

  assign clipped = (cnt_wval > CW'(DEPTH)) ? CW'(DEPTH) : cnt_wval;
  assign wr_en   = (state == TX_FILL) && dat_we;
  assign m_valid = (state == TX_SEND);
  assign m_last  = m_valid && ((rptr + CW'(1)) == count);
  assign active  = (state != TX_IDLE);

  mbx_bytebuf #(.DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wcnt[AW-1:0]),
    .wdata (dat_byte),
    .raddr (rptr[AW-1:0]),
    .rdata (m_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TX_IDLE;
      count      <= '0;
      wcnt       <= '0;
      rptr       <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      unique case (state)
        TX_IDLE: if (cnt_we && cnt_wval != '0) begin
          count <= clipped;
          wcnt  <= '0;
          state <= TX_FILL;
        end
        TX_FILL: if (dat_we) begin
          wcnt <= wcnt + 1'b1;
          if ((wcnt + CW'(1)) == count) begin
            rptr  <= '0;
            state <= TX_SEND;
          end
        end
        TX_SEND: if (m_ready) begin
          rptr <= rptr + 1'b1;
          if (m_last) begin
            count      <= '0;
            done_pulse <= 1'b1;
            state      <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  p_tx_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (count == '0 && $past(m_valid && m_ready && m_last)));

  p_tx_count_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_tx_count_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(m_valid && m_ready && m_last)) |=> $stable(count));
endmodule

// File: rtl/mbx_pktdev.sv
module mbx_pktdev
  import mbx_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAX_FRAME = 65536,
  parameter int VERSION   = 1,
  parameter logic [31:0] INFO = 32'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_last,
  input  logic        rx_ben,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        evt_tx_done,
  output logic        evt_rx_done,
  output logic        evt_test
);
  localparam int CW = $clog2(MAX_FRAME + 1);
  localparam logic [63:0] IDENT = ident_word(VERSION);

  logic [3:0]    widx;
  logic          rd_rxdata, wr_txcnt, wr_txdata, wr_evctl, rd_evctl;
  logic [CW-1:0] rx_count, tx_count;
  logic [7:0]    rx_byte;
  logic          rx_pend, rx_in_frame, tx_active;
  logic          tx_pend, test_flag;
  logic [31:0]   evctl, rd_mux;
  logic          unused_wbits;

  assign widx      = bus_addr[5:2];
  assign rd_rxdata = bus_rd && (widx == W_RXDATA);
  assign rd_evctl  = bus_rd && (widx == W_EVCTL);
  assign wr_evctl  = bus_wr && (widx == W_EVCTL);
  assign wr_txcnt  = bus_wr && (widx == W_TXCNT);
  assign wr_txdata = bus_wr && (widx == W_TXDATA);
  assign unused_wbits = ^{bus_wdata[30:CW], bus_addr[1:0]};

  mbx_rx_path #(.DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (rx_valid),
    .s_ready    (rx_ready),
    .s_data     (rx_data),
    .s_sof      (rx_sof),
    .s_last     (rx_last),
    .s_ben      (rx_ben),
    .pop        (rd_rxdata),
    .pend_clr   (wr_evctl && bus_wdata[EV_RX]),
    .pop_data   (rx_byte),
    .count      (rx_count),
    .pend       (rx_pend),
    .done_pulse (evt_rx_done),
    .in_frame   (rx_in_frame)
  );

  mbx_tx_path #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_we     (wr_txcnt),
    .cnt_wval   (bus_wdata[CW-1:0]),
    .dat_we     (wr_txdata),
    .dat_byte   (bus_wdata[7:0]),
    .m_valid    (tx_valid),
    .m_ready    (tx_ready),
    .m_data     (tx_data),
    .m_last     (tx_last),
    .count      (tx_count),
    .done_pulse (evt_tx_done),
    .active     (tx_active)
  );

  always_comb begin
    evctl          = '0;
    evctl[EV_TX]   = tx_pend;
    evctl[EV_RX]   = rx_pend;
    evctl[EV_TEST] = test_flag;
  end

  always_comb begin
    unique case (widx)
      W_ID_LO:  rd_mux = IDENT[31:0];
      W_ID_HI:  rd_mux = IDENT[63:32];
      W_BUSY:   rd_mux = {31'd0, rx_in_frame | tx_active};
      W_RXCNT:  rd_mux = 32'(rx_count);
      W_TXCNT:  rd_mux = 32'(tx_count);
      W_EVCTL:  rd_mux = evctl;
      W_INFO:   rd_mux = INFO;
      W_RXDATA: rd_mux = {24'd0, rx_byte};
      default:  rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      tx_pend   <= 1'b0;
      test_flag <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (wr_evctl && bus_wdata[EV_TX]) tx_pend <= 1'b0;
      if (evt_tx_done) tx_pend <= 1'b1;
      if (rd_evctl) test_flag <= 1'b0;
      if (wr_evctl) test_flag <= bus_wdata[EV_TEST];
    end
  end

  assign evt_test = test_flag;

  p_rx_done_loads_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_done |-> (rx_count != '0 && rx_pend && !rx_ready));

  p_rx_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_done |=> !evt_rx_done);

  p_tx_done_sets_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_done |=> tx_pend);

  p_busy_when_tx_loaded_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count != '0) |-> tx_active);
endmodule

// File: tb/sim_mbx_pktdev.sv
module sim_mbx_pktdev;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_last = 1'b0, rx_ben = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        evt_tx_done, evt_rx_done, evt_test;

  int checks = 0, fails = 0;
  logic [7:0] exp_tx [8];

  always #2 clk = ~clk;

  mbx_pktdev u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rx_beat(input logic [7:0] d, input logic sof, input logic last, input logic ben);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_sof = sof; rx_last = last; rx_ben = ben;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_last = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R2 rx_ready", 32'(rx_ready), 32'd1);
    chk("R2 tx_valid", 32'(tx_valid), 32'd0);
    rd(6'h08, v); chk("R2 busy", v, 0);
    rd(6'h0C, v); chk("R2 rx count", v, 0);
    rd(6'h10, v); chk("R2 tx count", v, 0);
    rd(6'h14, v); chk("R2 evctl", v, 0);
  endtask

  task automatic t_ident();
    logic [31:0] v;
    rd(6'h00, v); chk("R1 id low", v, 32'h45545942);
    rd(6'h04, v); chk("R1 id high", v, 32'h31545250);
    rd(6'h18, v); chk("R14 info", v, 32'd2);
    rd(6'h20, v); chk("R14 txdata reads zero", v, 0);
  endtask

  task automatic t_rx_basic();
    logic [31:0] v;
    rx_beat(8'hA1, 1'b1, 1'b0, 1'b1);
    rx_beat(8'hB2, 1'b0, 1'b0, 1'b1);
    rd(6'h08, v); chk("R12 busy mid rx frame", v, 1);
    rx_beat(8'hC3, 1'b0, 1'b1, 1'b1);
    chk("R3 rx done pulse", 32'(evt_rx_done), 1);
    @(negedge clk); chk("R3 rx done one cycle", 32'(evt_rx_done), 0);
    chk("R5 not ready with data held", 32'(rx_ready), 0);
    rd(6'h0C, v); chk("R3 rx count", v, 3);
    rd(6'h14, v); chk("R3 evctl rx bit", v, 32'h2);
    rd(6'h1C, v); chk("R4 byte 0", v, 32'hA1);
    rd(6'h0C, v); chk("R4 count after pop", v, 2);
    rd(6'h1C, v); chk("R4 byte 1", v, 32'hB2);
    rd(6'h1C, v); chk("R4 byte 2", v, 32'hC3);
    rd(6'h1C, v); chk("R4 read at zero", v, 0);
    rd(6'h0C, v); chk("R4 count stays zero", v, 0);
    chk("R5 not ready while pending", 32'(rx_ready), 0);
    wr(6'h14, 32'h2);
    @(negedge clk);
    chk("R5 ready after ack", 32'(rx_ready), 1);
    rd(6'h14, v); chk("R5 evctl cleared", v, 0);
  endtask

  task automatic t_rx_zero();
    logic [31:0] v;
    rx_beat(8'h00, 1'b1, 1'b1, 1'b0);
    chk("R6 no rx done", 32'(evt_rx_done), 0);
    rd(6'h0C, v); chk("R6 count zero", v, 0);
    rd(6'h14, v); chk("R6 no pending", v, 0);
    chk("R6 still ready", 32'(rx_ready), 1);
  endtask

  task automatic t_rx_restart();
    logic [31:0] v;
    rx_beat(8'h11, 1'b1, 1'b0, 1'b1);
    rx_beat(8'h22, 1'b0, 1'b0, 1'b1);
    rx_beat(8'h77, 1'b1, 1'b0, 1'b1);
    rx_beat(8'h88, 1'b0, 1'b1, 1'b1);
    rd(6'h0C, v); chk("R7 restarted count", v, 2);
    rd(6'h1C, v); chk("R7 first byte", v, 32'h77);
    rd(6'h1C, v); chk("R7 second byte", v, 32'h88);
    wr(6'h14, 32'h2);
  endtask

  task automatic t_rx_overlong();
    logic [31:0] v;
    int bad = 0;
    for (int i = 0; i < 70; i++)
      rx_beat(8'(i + 1), i == 0, i == 69, 1'b1);
    rd(6'h0C, v); chk("R8 count clipped", v, 64);
    for (int i = 0; i < 64; i++) begin
      rd(6'h1C, v);
      if (v !== 32'(i + 1)) bad++;
    end
    chk("R8 stored bytes", 32'(bad), 0);
    rd(6'h0C, v); chk("R8 drained", v, 0);
    wr(6'h14, 32'h2);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    int got = 0, cyc = 0;
    logic hold = 1'b0;
    logic [7:0] held = '0;
    exp_tx[0] = 8'h10; exp_tx[1] = 8'h20; exp_tx[2] = 8'h30; exp_tx[3] = 8'h40;
    tx_ready = 1'b0;
    wr(6'h10, 32'd4);
    rd(6'h08, v); chk("R12 busy with tx count", v, 1);
    wr(6'h10, 32'd9);
    rd(6'h10, v); chk("R11 count write ignored", v, 4);
    for (int i = 0; i < 4; i++) wr(6'h20, {24'hFFFFFF, exp_tx[i]});
    wr(6'h20, 32'hEE);
    chk("R9 stream starts", 32'(tx_valid), 1);
    while (got < 4) begin
      @(negedge clk);
      if (hold) chk("R10 held beat stable", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, held});
      hold = 1'b0;
      tx_ready = cyc[0];
      if (tx_valid) begin
        if (tx_ready) begin
          chk("R9 tx byte", 32'(tx_data), 32'(exp_tx[got]));
          chk("R9 tx last", 32'(tx_last), 32'(got == 3));
          got++;
        end else begin
          hold = 1'b1; held = tx_data;
        end
      end
      cyc++;
      if (cyc > 100) break;
    end
    @(negedge clk); tx_ready = 1'b0;
    chk("R11 tx done pulse", 32'(evt_tx_done), 1);
    chk("R9 no extra byte", 32'(tx_valid), 0);
    rd(6'h10, v); chk("R11 tx count cleared", v, 0);
    rd(6'h14, v); chk("R11 evctl tx bit", v, 32'h1);
    wr(6'h14, 32'h1);
    rd(6'h14, v); chk("R11 tx bit acked", v, 0);
    wr(6'h10, 32'd100);
    rd(6'h10, v); chk("R9 tx count clipped", v, 64);
  endtask

  task automatic t_test_bit();
    logic [31:0] v;
    wr(6'h14, 32'h8000_0000);
    chk("R13 test flag set", 32'(evt_test), 1);
    rd(6'h14, v); chk("R13 bit31 read", v[31], 1);
    rd(6'h14, v); chk("R13 cleared by read", v[31], 0);
    chk("R13 flag low after read", 32'(evt_test), 0);
    wr(6'h14, 32'h8000_0000);
    wr(6'h14, 32'h0);
    chk("R13 cleared by zero write", 32'(evt_test), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_rx_basic();
    t_rx_zero();
    t_rx_restart();
    t_rx_overlong();
    t_test_bit();
    t_tx();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule